// File: doc/BRIEF.md
# Sum-of-Products Engine

This block computes a signed dot product of two arrays held in memory without help from the sequencer that starts it. The caller supplies a start pointer for each array, a term count and an initial accumulator value, then pulses `start`. The engine fetches one element from each array per term through a single synchronous read port, multiplies the pair as signed numbers and adds the product into the accumulator. After each term both pointers advance by the element size and the count drops by one.

A size input picks byte or word elements. In byte mode each product is added into the low half of the accumulator and the high half is left alone. In word mode the full double-width accumulator is used. A signed overflow of the active accumulator width sets a sticky overflow flag and ends the run after the term that caused it. While a run is in progress an interrupt-block output stays high, so the surrounding core defers interrupts until the whole sum is finished.

Top module: `sop_engine`

## Requirements
- R1: After reset, `busy`, `irq_block`, `done`, `ovf` and `mem_rd` are 0, and the pointer, count and accumulator outputs are 0.
- R2: A `start` pulse while idle loads both pointers, the count, the size and the accumulator from the inputs and clears `ovf`. A `start` pulse while `busy` is high has no effect on the run in progress or its results.
- R3: When the loaded count is 0, `done` is high in the cycle after the start edge, no memory read is issued, and the outputs equal the loaded values.
- R4: Each term takes three cycles: a read at the multiplicand pointer, then a read at the multiplier pointer, then the multiply-add. Read data is returned by memory one cycle after `mem_rd`. A run of N terms keeps `busy` high for 3N cycles.
- R5: In byte mode (`word_sz`=0) the operands are bits [7:0] of each read word taken as signed 8-bit values. The 16-bit signed product is added into `acc_o[15:0]`, `acc_o[31:16]` does not change, and both pointers advance by 1 per term.
- R6: In word mode (`word_sz`=1) the operands are the full 16-bit read words taken as signed values. The 32-bit signed product is added into all of `acc_o`, and both pointers advance by 2 per term.
- R7: `count_o` decreases by 1 per term, and the run completes when it reaches 0.
- R8: When an addition overflows the active accumulator width as a signed number, the wrapped sum is written and the pointers and count still advance for that term. `ovf` is then set, and the run ends with `done` in that same cycle, with no further reads.
- R9: `ovf` holds its value until the next accepted `start`.
- R10: `irq_block` is high in every cycle in which the engine is busy, and low while it is idle.
- R11: `done` is a one-cycle pulse in the cycle the engine goes idle. `busy` only falls together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| word_sz | input | 1 | 1 = word elements, 0 = byte elements |
| mcand_ptr_i | input | 16 | Multiplicand array start address |
| mplier_ptr_i | input | 16 | Multiplier array start address |
| count_i | input | 16 | Number of terms |
| acc_i | input | 32 | Initial accumulator value |
| mem_rd | output | 1 | Read request this cycle |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Run in progress |
| irq_block | output | 1 | Hold off interrupt acknowledge |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Sticky accumulator overflow flag |
| mcand_ptr_o | output | 16 | Current multiplicand pointer |
| mplier_ptr_o | output | 16 | Current multiplier pointer |
| count_o | output | 16 | Remaining term count |
| acc_o | output | 32 | Accumulator |

## Verification
The bench builds the block with its default parameters: 8-bit byte lanes, 16-bit words, a 32-bit accumulator and 16-bit pointers and count. With these widths a few terms of near-maximum operands are enough to overflow either lane, so early termination can be tested in both sizes with short runs. The bench memory decodes only the low eight address bits, which leaves room for separate arrays per scenario. Small counts also keep the exact three-cycle-per-term timing easy to observe, including the zero-count case and a start pulse that arrives in the middle of a run.

// File: rtl/sop_pkg.sv
package sop_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RDA  = 2'd1,
      ST_RDB  = 2'd2,
      ST_MAC  = 2'd3
   } sop_state_e;

   localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/sop_addr_step.sv
module sop_addr_step #(
   parameter int unsigned AW = 16,
   parameter int unsigned CW = 16
) (
   input  logic [AW-1:0] pa,
   input  logic [AW-1:0] pb,
   input  logic [CW-1:0] cnt,
   input  logic          word,
   output logic [AW-1:0] pa_nx,
   output logic [AW-1:0] pb_nx,
   output logic [CW-1:0] cnt_nx
);
   logic [AW-1:0] step;

   assign step   = word ? AW'(2) : AW'(1);
   assign pa_nx  = pa + step;
   assign pb_nx  = pb + step;
   assign cnt_nx = cnt - CW'(1);
endmodule

// File: rtl/sop_mac_unit.sv
module sop_mac_unit #(
   parameter int unsigned OP_W = 8
) (
   input  logic [2*OP_W-1:0] opa,
   input  logic [2*OP_W-1:0] opb,
   input  logic [4*OP_W-1:0] acc,
   input  logic              word,
   output logic [4*OP_W-1:0] acc_nx,
   output logic              ov
);
   import sop_pkg::*;

   localparam int unsigned ACC_W = 4 * OP_W;

   logic [ACC_W-1:0] lane_acc [NUM_LANES];
   logic             lane_ov  [NUM_LANES];

   // lane 0: byte operands into half accumulator, lane 1: word operands into full
   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      localparam int unsigned OW = OP_W << l;
      localparam int unsigned SW = 2 * OW;

      logic signed [OW-1:0] a_l;
      logic signed [OW-1:0] b_l;
      logic signed [SW-1:0] prod;
      logic        [SW-1:0] base;
      logic        [SW-1:0] sum;

      assign a_l  = opa[OW-1:0];
      assign b_l  = opb[OW-1:0];
      assign prod = a_l * b_l;
      assign base = acc[SW-1:0];
      assign sum  = base + prod;
      assign lane_ov[l] = (base[SW-1] == prod[SW-1]) && (sum[SW-1] != base[SW-1]);

      if (SW < ACC_W) begin : g_keep_hi
         assign lane_acc[l] = {acc[ACC_W-1:SW], sum};
      end else begin : g_full
         assign lane_acc[l] = sum;
      end
   end

   assign acc_nx = word ? lane_acc[1] : lane_acc[0];
   assign ov     = word ? lane_ov[1]  : lane_ov[0];
endmodule

// File: rtl/sop_engine.sv
module sop_engine #(
   parameter int unsigned OP_W   = 8,
   parameter int unsigned AW     = 16,
   parameter int unsigned CW     = 16,
   localparam int unsigned WORD_W = 2 * OP_W,
   localparam int unsigned ACC_W  = 4 * OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              word_sz,
   input  logic [AW-1:0]     mcand_ptr_i,
   input  logic [AW-1:0]     mplier_ptr_i,
   input  logic [CW-1:0]     count_i,
   input  logic [ACC_W-1:0]  acc_i,
   output logic              mem_rd,
   output logic [AW-1:0]     mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              irq_block,
   output logic              done,
   output logic              ovf,
   output logic [AW-1:0]     mcand_ptr_o,
   output logic [AW-1:0]     mplier_ptr_o,
   output logic [CW-1:0]     count_o,
   output logic [ACC_W-1:0]  acc_o
);
   import sop_pkg::*;

   if (OP_W < 2) begin : g_bad_op_w
      $error("sop_engine: OP_W must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("sop_engine: AW must be at least 2");
   end
   if (CW < 1) begin : g_bad_cw
      $error("sop_engine: CW must be at least 1");
   end

   sop_state_e        state_q;
   logic [AW-1:0]     pa_q, pb_q;
   logic [CW-1:0]     cnt_q;
   logic [ACC_W-1:0]  acc_q;
   logic              word_q;
   logic              ovf_q;
   logic              done_q;
   logic [WORD_W-1:0] opa_q;

   logic [AW-1:0]     pa_nx, pb_nx;
   logic [CW-1:0]     cnt_nx;
   logic [ACC_W-1:0]  acc_nx;
   logic              term_ov;

   sop_addr_step #(.AW(AW), .CW(CW)) u_step (
      .pa     (pa_q),
      .pb     (pb_q),
      .cnt    (cnt_q),
      .word   (word_q),
      .pa_nx  (pa_nx),
      .pb_nx  (pb_nx),
      .cnt_nx (cnt_nx)
   );

   sop_mac_unit #(.OP_W(OP_W)) u_mac (
      .opa    (opa_q),
      .opb    (mem_rdata),
      .acc    (acc_q),
      .word   (word_q),
      .acc_nx (acc_nx),
      .ov     (term_ov)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pa_q    <= '0;
         pb_q    <= '0;
         cnt_q   <= '0;
         acc_q   <= '0;
         word_q  <= 1'b0;
         ovf_q   <= 1'b0;
         done_q  <= 1'b0;
         opa_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  pa_q   <= mcand_ptr_i;
                  pb_q   <= mplier_ptr_i;
                  cnt_q  <= count_i;
                  acc_q  <= acc_i;
                  word_q <= word_sz;
                  ovf_q  <= 1'b0;
                  if (count_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= ST_RDA;
                  end
               end
            end
            ST_RDA: state_q <= ST_RDB;
            ST_RDB: begin
               opa_q   <= mem_rdata;
               state_q <= ST_MAC;
            end
            ST_MAC: begin
               acc_q <= acc_nx;
               pa_q  <= pa_nx;
               pb_q  <= pb_nx;
               cnt_q <= cnt_nx;
               if (term_ov || cnt_nx == '0) begin
                  ovf_q   <= term_ov;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_RDA;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd       = (state_q == ST_RDA) || (state_q == ST_RDB);
   assign mem_addr     = (state_q == ST_RDB) ? pb_q : pa_q;
   assign busy         = (state_q != ST_IDLE);
   assign irq_block    = busy;
   assign done         = done_q;
   assign ovf          = ovf_q;
   assign mcand_ptr_o  = pa_q;
   assign mplier_ptr_o = pb_q;
   assign count_o      = cnt_q;
   assign acc_o        = acc_q;
endmodule

// File: rtl/sop_engine_checker.sv
module sop_engine_checker #(
   parameter int unsigned AW = 16,
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [CW-1:0] count_i,
   input logic          busy,
   input logic          done,
   input logic          ovf,
   input logic          irq_block,
   input logic          mem_rd,
   input logic [AW-1:0] mcand_ptr_o,
   input logic [CW-1:0] count_o,
   input logic          word_q
);
   // R11: a run ends only through a done pulse
   assert_busy_ends_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   // R10: memory traffic happens only with interrupts held off
   assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> irq_block);

   // R7: remaining count only ever steps down by one
   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && count_o != $past(count_o)) |-> (count_o == $past(count_o) - CW'(1)));

   // R6 (and R5): pointer step equals the element size
   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && mcand_ptr_o != $past(mcand_ptr_o))
      |-> (mcand_ptr_o == $past(mcand_ptr_o) + ($past(word_q) ? AW'(2) : AW'(1))));

   // R8: overflow ends the run in the same cycle
   assert_ovf_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> (done && !busy));

   // R3: an empty run completes at once
   assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count_i == '0) |=> (done && !busy && !mem_rd));
endmodule

bind sop_engine sop_engine_checker #(.AW(AW), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .count_i     (count_i),
   .busy        (busy),
   .done        (done),
   .ovf         (ovf),
   .irq_block   (irq_block),
   .mem_rd      (mem_rd),
   .mcand_ptr_o (mcand_ptr_o),
   .count_o     (count_o),
   .word_q      (word_q)
);

// File: tb/tb_sop_engine.sv
module tb_sop_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        word_sz = 1'b0;
   logic [15:0] mcand_ptr_i = '0;
   logic [15:0] mplier_ptr_i = '0;
   logic [15:0] count_i = '0;
   logic [31:0] acc_i = '0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        busy, irq_block, done, ovf;
   logic [15:0] mcand_ptr_o, mplier_ptr_o, count_o;
   logic [31:0] acc_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [15:0] tbmem [256];

   always #10 clk = ~clk;

   always_ff @(posedge clk) begin
      if (mem_rd) mem_rdata <= tbmem[mem_addr[7:0]];
   end

   sop_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_sz(word_sz),
      .mcand_ptr_i(mcand_ptr_i), .mplier_ptr_i(mplier_ptr_i),
      .count_i(count_i), .acc_i(acc_i),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .irq_block(irq_block), .done(done), .ovf(ovf),
      .mcand_ptr_o(mcand_ptr_o), .mplier_ptr_o(mplier_ptr_o),
      .count_o(count_o), .acc_o(acc_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic longint elem(input bit w, input logic [15:0] a);
      if (w) return longint'($signed(tbmem[a[7:0]]));
      return longint'($signed(tbmem[a[7:0]][7:0]));
   endfunction

   // common runner: computes expectations from the requirements and checks them
   task automatic run_job(input bit w, input logic [15:0] pa, input logic [15:0] pb,
                          input logic [15:0] cnt, input logic [31:0] acc0,
                          input string tag, input bit poke);
      logic [15:0] epa = pa, epb = pb, ecnt = cnt;
      logic [31:0] eacc = acc0;
      bit          eov = 1'b0;
      int          terms = 0;
      int          busy_cyc = 0, irq_bad = 0, nreads = 0, cyc = 0;
      logic [15:0] rd0 = '0, rd1 = '0;
      while (ecnt != 0 && !eov) begin
         longint p = elem(w, epa) * elem(w, epb);
         longint s;
         if (w) begin
            s = longint'($signed(eacc)) + p;
            eov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            eacc = s[31:0];
         end else begin
            s = longint'($signed(eacc[15:0])) + p;
            eov = (s > 64'sd32767) || (s < -64'sd32768);
            eacc[15:0] = s[15:0];
         end
         epa += w ? 16'd2 : 16'd1;
         epb += w ? 16'd2 : 16'd1;
         ecnt -= 16'd1;
         terms++;
      end
      @(negedge clk);
      word_sz = w; mcand_ptr_i = pa; mplier_ptr_i = pb; count_i = cnt; acc_i = acc0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 1000) begin
         if (irq_block != busy) irq_bad++;
         if (busy) busy_cyc++;
         if (mem_rd) begin
            if (nreads == 0) rd0 = mem_addr;
            if (nreads == 1) rd1 = mem_addr;
            nreads++;
         end
         if (poke && cyc == 2) begin
            start = 1'b1; word_sz = ~w; count_i = 16'h0055; acc_i = 32'hDEAD_BEEF;
            mcand_ptr_i = 16'h00F0; mplier_ptr_i = 16'h00F8;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(done == 1'b1, {"R11 done seen ", tag}, done, 1);
      chk(busy == 1'b0, {"R11 idle with done ", tag}, busy, 0);
      chk(busy_cyc == 3 * terms, {"R4 busy cycles ", tag}, busy_cyc, 3 * terms);
      chk(nreads == 2 * terms, {"R4 read count ", tag}, nreads, 2 * terms);
      if (terms > 0) begin
         chk(rd0 == pa, {"R4 first read at multiplicand ", tag}, rd0, pa);
         chk(rd1 == pb, {"R4 second read at multiplier ", tag}, rd1, pb);
      end
      chk(acc_o == eacc, {(w ? "R6" : "R5"), " accumulator ", tag}, acc_o, eacc);
      chk(mcand_ptr_o == epa, {(w ? "R6" : "R5"), " multiplicand pointer ", tag}, mcand_ptr_o, epa);
      chk(mplier_ptr_o == epb, {(w ? "R6" : "R5"), " multiplier pointer ", tag}, mplier_ptr_o, epb);
      chk(count_o == ecnt, {"R7 remaining count ", tag}, count_o, ecnt);
      chk(ovf == eov, {"R8 overflow flag ", tag}, ovf, eov);
      chk(irq_bad == 0, {"R10 irq_block tracks busy ", tag}, irq_bad, 0);
      @(negedge clk);
      chk(done == 1'b0, {"R11 done one cycle ", tag}, done, 0);
      chk(ovf == eov, {"R9 overflow held ", tag}, ovf, eov);
   endtask

   task automatic t_reset();
      chk(busy == 0 && irq_block == 0 && done == 0 && ovf == 0 && mem_rd == 0,
          "R1 control outputs after reset", {busy, irq_block, done, ovf, mem_rd}, 0);
      chk(acc_o == 0 && count_o == 0 && mcand_ptr_o == 0 && mplier_ptr_o == 0,
          "R1 state outputs after reset", acc_o, 0);
   endtask

   task automatic t_zero_count();   // R3
      run_job(1'b1, 16'h0010, 16'h0030, 16'd0, 32'hCAFE_0042, "R3 zero count", 1'b0);
   endtask

   task automatic t_byte();         // R5 with mixed signs and a preloaded high half
      run_job(1'b0, 16'h0010, 16'h0030, 16'd4, 32'h1234_0010, "byte run", 1'b0);
   endtask

   task automatic t_word();         // R6
      run_job(1'b1, 16'h0040, 16'h0060, 16'd3, 32'hFFFF_FF00, "word run", 1'b0);
   endtask

   task automatic t_word_ovf();     // R8 word lane, stops after third term
      run_job(1'b1, 16'h0080, 16'h00A0, 16'd5, 32'h0, "R8 word overflow", 1'b0);
   endtask

   task automatic t_byte_ovf();     // R8 byte lane
      run_job(1'b0, 16'h00C0, 16'h00E0, 16'd5, 32'hA5A5_0000, "R8 byte overflow", 1'b0);
   endtask

   task automatic t_ovf_cleared();  // R9 next start clears the flag
      run_job(1'b0, 16'h0010, 16'h0030, 16'd1, 32'h0, "R9 flag cleared by start", 1'b0);
   endtask

   task automatic t_start_busy();   // R2 start during a run is ignored
      run_job(1'b1, 16'h0040, 16'h0060, 16'd3, 32'h0000_0007, "R2 start while busy", 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) tbmem[i] = 16'(i * 37 + 5);
      tbmem[8'h10] = 16'h00FD; tbmem[8'h11] = 16'h0007; tbmem[8'h12] = 16'h0080; tbmem[8'h13] = 16'h007F;
      tbmem[8'h30] = 16'h0005; tbmem[8'h31] = 16'h00F9; tbmem[8'h32] = 16'h0002; tbmem[8'h33] = 16'h0003;
      tbmem[8'h40] = 16'h8000; tbmem[8'h42] = 16'h1234; tbmem[8'h44] = 16'hFFFF;
      tbmem[8'h60] = 16'h0003; tbmem[8'h62] = 16'hFF00; tbmem[8'h64] = 16'h7FFF;
      for (int i = 0; i < 16; i++) begin
         tbmem[8'h80 + i] = 16'h7FFF; tbmem[8'hA0 + i] = 16'h7FFF;
         tbmem[8'hC0 + i] = 16'h007F; tbmem[8'hE0 + i] = 16'h007F;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_zero_count();
      t_byte();
      t_word();
      t_word_ovf();
      t_ovf_cleared();
      t_byte_ovf();
      t_start_busy();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule